// File: doc/BRIEF.md
# Carrier-Gated HDLC Frame Collector

This block sits behind a byte-oriented HDLC receiver and turns its byte stream into whole frames held in a local buffer. It works only while the carrier detect input is high. Each time a carrier session opens, the first five bytes from the receiver are treated as stale and thrown away. After that, the block stores incoming bytes until the receiver signals the end of a frame. A frame that passes its CRC check and has more than four bytes is offered downstream with a length that leaves out its last byte. Frames that fail the CRC check, are aborted, or are too long are dropped, and the block starts filling the buffer again from address zero.

Downstream logic accepts a frame through a valid/ready pair. It reads the stored bytes through a synchronous read port that has one cycle of latency. When a frame overflows the configured buffer size, the block asks the receiver to hunt for the next flag. Three free-running event counters record completed frames, carrier sessions and bytes lost because a finished frame was still waiting to be taken.

Top module: `hdlc_carrier_collector`

## Requirements
- R1: When carrier detect is seen high while the block is idle, the block counts one carrier event. It then discards the next five bytes with `rx_valid` high. The sixth byte is stored at buffer address 0.
- R2: Whenever carrier detect is low and no frame is waiting, the block returns to idle within one cycle. The partial frame is abandoned, and bytes that arrive while idle are ignored.
- R3: When `rx_abort` is high while collecting, the byte count returns to zero without leaving the session. The next byte is stored at address 0.
- R4: A byte that arrives when the count already equals `cfg_buf_size` is not stored. It sets the count back to zero and raises `hunt_req` for exactly one cycle, starting on the clock edge that takes the byte. A frame of exactly `cfg_buf_size` bytes raises no hunt request.
- R5: An end-of-frame with `rx_crc_err` high delivers nothing and sets the count back to zero.
- R6: An end-of-frame without a CRC error and with a count of 4 or less delivers nothing. A larger count N raises `frame_valid` one clock edge later with `frame_len` = N-1. The N bytes are readable at addresses 0..N-1.
- R7: `frame_valid` and `frame_len` stay unchanged until a cycle with `frame_ready` high. After that cycle `frame_valid` is low, and if carrier is still present, collection resumes without a new flush.
- R8: Bytes that arrive while `frame_valid` is high are not stored. Each one adds one to `overruns`.
- R9: `good_frames` increases by one for each delivered frame, and `carrier_events` by one for each session opened.
- R10: While `rst_n` is low at a clock edge, every pointer, state and counter is cleared: `frame_valid`, `hunt_req` and all three counters read 0.
- R11: `rd_data` presents the byte at `rd_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_buf_size | input | 12 | Buffer size limit in bytes, 1 to MAX_BUF |
| dcd | input | 1 | Carrier detect level |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame pulse |
| rx_crc_err | input | 1 | CRC error flag, qualified by rx_eof |
| rx_abort | input | 1 | Abort indication from receiver |
| hunt_req | output | 1 | One-cycle request for the receiver to hunt for a flag |
| frame_valid | output | 1 | A completed frame is waiting |
| frame_len | output | 12 | Delivered length (stored count minus one) |
| frame_ready | input | 1 | Downstream accepts the waiting frame |
| rd_addr | input | 11 | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |
| good_frames | output | 16 | Delivered-frame counter |
| carrier_events | output | 16 | Carrier-session counter |
| overruns | output | 16 | Bytes dropped while a frame waits |

## Verification
A byte count that is off by one shows up at the ports on the first end-of-frame that follows. It appears as a wrong `frame_len`, as a short frame that is delivered or a long one that is dropped, or as data shifted by one address when the buffer is read back. The same count error moves the `hunt_req` pulse by one byte. A state machine stuck in the wrong state shows up within one frame: flush bytes turn up in the buffer, a frame goes missing after a carrier drop, or the event counters drift away from the totals the bench keeps.

// File: rtl/hcc_pkg.sv
// Shared types for the carrier-gated frame collector.
package hcc_pkg;
    // Collector states: waiting for carrier, discarding stale bytes,
    // filling the buffer, holding a finished frame for hand-off.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FLUSH   = 2'd1,
        ST_COLLECT = 2'd2,
        ST_HOLD    = 2'd3
    } hcc_state_e;
endpackage

// File: rtl/hcc_frame_mem.sv
// Frame buffer: single write port, registered read port.
// Assumes the writer and the reader never need the same address in the
// same cycle (the controller only writes while no frame is held).
module hcc_frame_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    // Store one byte per accepted write.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Present the addressed byte one edge later.
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end
endmodule

// File: rtl/hcc_event_ctr.sv
// Wrapping event counter with synchronous active-low clear.
// Assumes inc is a single-cycle qualified event.
module hcc_event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Add one per event, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/hcc_rx_fsm.sv
// Collection controller: flushes stale bytes after carrier appears, counts
// and addresses stored bytes, screens finished frames and holds a good one
// until the consumer takes it. Assumes cfg_buf_size is between 1 and
// MAX_BUF, and that rx_valid and rx_eof are not high in the same cycle
// (if they are, the byte wins).
module hcc_rx_fsm
    import hcc_pkg::*;
#(
    parameter int MAX_BUF     = 2048,
    parameter int FLUSH_BYTES = 5,
    parameter int MIN_GOOD    = 4,
    localparam int LEN_W  = $clog2(MAX_BUF + 1),
    localparam int ADDR_W = $clog2(MAX_BUF),
    localparam int FL_W   = $clog2(FLUSH_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dcd,
    input  logic              rx_valid,
    input  logic              rx_eof,
    input  logic              rx_crc_err,
    input  logic              rx_abort,
    input  logic [LEN_W-1:0]  cfg_buf_size,
    input  logic              frame_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              frame_valid,
    output logic [LEN_W-1:0]  frame_len,
    output logic              hunt_req,
    output logic              ev_carrier,
    output logic              ev_good,
    output logic              ev_overrun
);
    hcc_state_e       state;
    logic [LEN_W-1:0] cnt;
    logic [FL_W-1:0]  fl_cnt;
    logic             collecting;
    logic             eof_good;

    // Qualify the active collection cycle and a frame that passes screening.
    always_comb begin
        collecting = (state == ST_COLLECT) && dcd && !rx_abort;
        eof_good   = collecting && !rx_valid && rx_eof && !rx_crc_err
                     && (cnt > LEN_W'(MIN_GOOD));
    end

    // Drive the buffer write and the event pulses for the counters.
    always_comb begin
        mem_we      = collecting && rx_valid && (cnt < cfg_buf_size);
        mem_waddr   = cnt[ADDR_W-1:0];
        frame_valid = (state == ST_HOLD);
        ev_carrier  = (state == ST_IDLE) && dcd;
        ev_good     = eof_good;
        ev_overrun  = (state == ST_HOLD) && rx_valid;
    end

    // Advance the session state, byte count and flush count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            fl_cnt    <= '0;
            frame_len <= '0;
            hunt_req  <= 1'b0;
        end else begin
            hunt_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (dcd) begin
                        state  <= ST_FLUSH;
                        fl_cnt <= '0;
                    end
                end
                ST_FLUSH: begin
                    if (!dcd) begin
                        state <= ST_IDLE;
                    end else if (rx_valid) begin
                        if (fl_cnt == FL_W'(FLUSH_BYTES - 1)) begin
                            state <= ST_COLLECT;
                            cnt   <= '0;
                        end else begin
                            fl_cnt <= fl_cnt + FL_W'(1);
                        end
                    end
                end
                ST_COLLECT: begin
                    if (!dcd) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (rx_abort) begin
                        cnt <= '0;
                    end else if (rx_valid) begin
                        if (cnt >= cfg_buf_size) begin
                            hunt_req <= 1'b1;
                            cnt      <= '0;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                        end
                    end else if (rx_eof) begin
                        if (eof_good) begin
                            frame_len <= cnt - LEN_W'(1);
                            state     <= ST_HOLD;
                        end
                        cnt <= '0;
                    end
                end
                ST_HOLD: begin
                    if (frame_ready) state <= dcd ? ST_COLLECT : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: without carrier and no held frame, the session closes at once.
    a_r2_carrier_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (!dcd && state != ST_HOLD) |=> (state == ST_IDLE));

    // R3: an abort while collecting never completes a frame.
    a_r3_abort_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && dcd && rx_abort) |=> !frame_valid);

    // R4: a hunt request follows a received byte and lasts one cycle.
    a_r4_hunt_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |-> $past(rx_valid));
    a_r4_hunt_single: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |=> !hunt_req);

    // R6: a delivered length always reflects more than four stored bytes.
    a_r6_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_len >= LEN_W'(MIN_GOOD)));

    // R7: a waiting frame stays offered and unchanged until taken.
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_ready) |=> (frame_valid && $stable(frame_len)));

    // R8: nothing is written into the buffer while a frame waits.
    a_r8_no_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> !mem_we);
endmodule

// File: rtl/hdlc_carrier_collector.sv
// Top level: carrier-gated HDLC frame collector. Joins the controller, the
// frame buffer and three event counters. Assumes an upstream receiver that
// has already found flags, removed stuffed bits and checked the CRC.
module hdlc_carrier_collector #(
    parameter int DATA_W  = 8,
    parameter int MAX_BUF = 2048,
    parameter int CTR_W   = 16,
    localparam int LEN_W  = $clog2(MAX_BUF + 1),
    localparam int ADDR_W = $clog2(MAX_BUF),
    localparam int N_CTR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_buf_size,
    input  logic              dcd,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eof,
    input  logic              rx_crc_err,
    input  logic              rx_abort,
    output logic              hunt_req,
    output logic              frame_valid,
    output logic [LEN_W-1:0]  frame_len,
    input  logic              frame_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTR_W-1:0]  good_frames,
    output logic [CTR_W-1:0]  carrier_events,
    output logic [CTR_W-1:0]  overruns
);
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [N_CTR-1:0]  ev;
    logic [CTR_W-1:0]  ctr_val [N_CTR];

    hcc_rx_fsm #(
        .MAX_BUF (MAX_BUF)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .dcd          (dcd),
        .rx_valid     (rx_valid),
        .rx_eof       (rx_eof),
        .rx_crc_err   (rx_crc_err),
        .rx_abort     (rx_abort),
        .cfg_buf_size (cfg_buf_size),
        .frame_ready  (frame_ready),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .frame_valid  (frame_valid),
        .frame_len    (frame_len),
        .hunt_req     (hunt_req),
        .ev_carrier   (ev[0]),
        .ev_good      (ev[1]),
        .ev_overrun   (ev[2])
    );

    hcc_frame_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_BUF)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (rx_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // One counter per event line: carrier sessions, good frames, overruns.
    for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
        hcc_event_ctr #(.W(CTR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[g]),
            .count (ctr_val[g])
        );
    end

    assign carrier_events = ctr_val[0];
    assign good_frames    = ctr_val[1];
    assign overruns       = ctr_val[2];
endmodule

// File: tb/hdlc_carrier_collector_test.sv
module hdlc_carrier_collector_test;
    localparam int LEN_W  = 12;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [LEN_W-1:0]  cfg_buf_size;
    logic              dcd, rx_valid, rx_eof, rx_crc_err, rx_abort;
    logic [7:0]        rx_data;
    logic              hunt_req, frame_valid, frame_ready;
    logic [LEN_W-1:0]  frame_len;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic [15:0]       good_frames, carrier_events, overruns;

    int n_checks = 0;
    int n_errors = 0;
    int exp_good = 0;
    int exp_carrier = 0;
    int exp_over = 0;
    bit done = 0;

    always #10 clk = ~clk;

    hdlc_carrier_collector uut (
        .clk(clk), .rst_n(rst_n), .cfg_buf_size(cfg_buf_size), .dcd(dcd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
        .rx_crc_err(rx_crc_err), .rx_abort(rx_abort), .hunt_req(hunt_req),
        .frame_valid(frame_valid), .frame_len(frame_len),
        .frame_ready(frame_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .good_frames(good_frames), .carrier_events(carrier_events),
        .overruns(overruns)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d);
        rx_valid = 1'b1; rx_data = d;
        cyc();
        rx_valid = 1'b0;
    endtask

    task automatic send_eof(input logic err);
        rx_eof = 1'b1; rx_crc_err = err;
        cyc();
        rx_eof = 1'b0; rx_crc_err = 1'b0;
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) send_byte(8'(seed + i));
    endtask

    // R1: open a carrier session and feed the five stale bytes
    task automatic carrier_on();
        dcd = 1'b1;
        cyc();
        exp_carrier++;
        for (int i = 0; i < 5; i++) send_byte(8'(8'hF0 + i));
    endtask

    task automatic read_check(input string tag, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            rd_addr = ADDR_W'(i);
            cyc();
            check(tag, int'(rd_data), (seed + i) & 255);
        end
    endtask

    task automatic accept();
        frame_ready = 1'b1;
        cyc();
        frame_ready = 1'b0;
    endtask

    task automatic check_counters(input string tag);
        check({tag, " good"}, int'(good_frames), exp_good);
        check({tag, " carrier"}, int'(carrier_events), exp_carrier);
        check({tag, " overrun"}, int'(overruns), exp_over);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dcd = 1'b0; rx_valid = 1'b0; rx_data = '0;
        rx_eof = 1'b0; rx_crc_err = 1'b0; rx_abort = 1'b0;
        frame_ready = 1'b0; rd_addr = '0; cfg_buf_size = 12'd12;
        repeat (3) cyc();
        // R10: reset state
        check("R10 frame_valid", int'(frame_valid), 0);
        check("R10 hunt_req", int'(hunt_req), 0);
        check_counters("R10");
        rst_n = 1'b1;
        cyc();

        // R2: bytes without carrier are ignored
        send_frame(6, 8'h90);
        send_eof(1'b0);
        check("R2 idle no frame", int'(frame_valid), 0);

        // R1: carrier rise then flush; first stored byte is the sixth
        carrier_on();
        check("R1 carrier count", int'(carrier_events), exp_carrier);

        // R6/R9/R11: sweep frame lengths 1..12 with buffer size 12
        for (int n = 1; n <= 12; n++) begin
            send_frame(n, 16 * n);
            send_eof(1'b0);
            if (n > 4) begin
                exp_good++;
                check("R6 frame_valid", int'(frame_valid), 1);
                check("R6 frame_len", int'(frame_len), n - 1);
                read_check("R11 read data", n, 16 * n);
                check("R7 still valid", int'(frame_valid), 1);
                accept();
                check("R7 released", int'(frame_valid), 0);
            end else begin
                check("R6 short dropped", int'(frame_valid), 0);
            end
            check("R9 good count", int'(good_frames), exp_good);
        end

        // R5: CRC error drops frame and resets count
        send_frame(7, 8'h30);
        send_eof(1'b1);
        check("R5 crc dropped", int'(frame_valid), 0);
        send_frame(5, 8'h50);
        send_eof(1'b0);
        exp_good++;
        check("R5 next len", int'(frame_len), 4);
        read_check("R5 next data", 5, 8'h50);
        accept();

        // R3: abort restarts at address 0
        send_frame(3, 8'hA0);
        rx_abort = 1'b1; cyc(); rx_abort = 1'b0;
        send_frame(6, 8'h40);
        send_eof(1'b0);
        exp_good++;
        check("R3 len", int'(frame_len), 5);
        read_check("R3 data", 6, 8'h40);
        accept();

        // R4: exactly buffer size, no hunt
        cfg_buf_size = 12'd8;
        for (int i = 0; i < 8; i++) begin
            send_byte(8'(8'h60 + i));
            check("R4 no hunt at limit", int'(hunt_req), 0);
        end
        send_eof(1'b0);
        exp_good++;
        check("R4 full len", int'(frame_len), 7);
        read_check("R4 full data", 8, 8'h60);
        accept();

        // R4: one past buffer size raises a single hunt pulse
        for (int i = 0; i < 9; i++) begin
            send_byte(8'(8'hC0 + i));
            check("R4 hunt timing", int'(hunt_req), (i == 8) ? 1 : 0);
        end
        cyc();
        check("R4 hunt one cycle", int'(hunt_req), 0);
        send_frame(6, 8'h20);
        send_eof(1'b0);
        exp_good++;
        check("R4 restart len", int'(frame_len), 5);
        read_check("R4 restart data", 6, 8'h20);

        // R8: bytes during hold are dropped and counted
        send_byte(8'hEE);
        send_byte(8'hEF);
        exp_over += 2;
        check("R8 overruns", int'(overruns), exp_over);
        check("R8 len kept", int'(frame_len), 5);
        read_check("R8 data kept", 6, 8'h20);
        accept();
        cfg_buf_size = 12'd12;

        // R2: carrier drop abandons partial frame
        send_frame(3, 8'hB0);
        dcd = 1'b0;
        cyc();
        send_frame(4, 8'hB3);
        send_eof(1'b0);
        check("R2 dropped", int'(frame_valid), 0);
        check("R2 good unchanged", int'(good_frames), exp_good);

        // R1: new session flushes again
        carrier_on();
        send_frame(6, 8'h70);
        send_eof(1'b0);
        exp_good++;
        check("R1 len after reflush", int'(frame_len), 5);
        read_check("R1 data after reflush", 6, 8'h70);
        accept();
        check_counters("R9 final");

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule